// File: doc/BRIEF.md
# CAN Controller Host Register Interface

This block is the register front end that sits between a simple 32-bit register bus and the bit-stream engine of a CAN controller. Software uses it to choose the operating mode, issue one-shot commands, read the controller status and the last captured bus-error and arbitration details, manage interrupts, and read or clear the error counts. The protocol engine sees the mode as levels and the commands as single-cycle pulses. It reports its activity back as event pulses, status levels and counter loads.

The controller leaves reset in its configuration (reset) mode. Two configuration bits, the sleep request and the acceptance-filter layout, can only be changed while that mode is in force. A single level interrupt output combines every pending and enabled event flag. The frame engine, the message storage and the acceptance filter are outside this block.

The register offsets are 0x00 mode, 0x04 command, 0x08 status, 0x0C interrupt flags, 0x10 interrupt enables and 0x14 error counts. A read is selected by `bus_sel_i`=1 with `bus_we_i`=0 and returns data in the same cycle. A write takes effect at the clock edge on which `bus_sel_i` and `bus_we_i` are both 1.

Top module: `can_host_regs`

## Requirements
- R1: After reset the mode register reads 0x01, the status register reads 0x0000003C, and the interrupt flags, interrupt enables and error-count register read 0. `mode_o` is 0x01 and `cmd_o` is 0.
- R2: In the mode register, bit 0 is reset mode, bit 1 listen-only, bit 2 loopback, bit 3 filter select (1 single, 0 dual) and bit 4 sleep. Bits 2:0 take every write. Bits 4:3 take a write only if bit 0 was 1 before that write. Otherwise they keep their value.
- R3: A command write drives its bits on `cmd_o` for exactly the cycle after the write, then `cmd_o` returns to 0. The bits are 0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-reception and 5 bus-off request. A read of offset 0x04 returns 0.
- R4: The release pulse (`cmd_o` bit 2) is issued only if status bit 0 (receive buffer ready) is 1 when the command is written. Otherwise the command has no effect.
- R5: Status bits 7:0 take the values of `eng_stat_i` one cycle later, except bit 1 (data overrun). Bit 1 is a latch that is set by `evt_i` bit 3 whether or not that interrupt is enabled, and cleared by a clear-overrun command. If both arrive in one cycle, the set wins.
- R6: When `evt_i` bit 7 (bus error) pulses, status bits 23:22 capture the error type (0 bit, 1 form, 2 stuff, 3 other), bit 21 captures the direction (0 transmit, 1 receive) and bits 20:16 capture the segment code. These fields hold their value between bus errors.
- R7: When `evt_i` bit 6 (arbitration lost) pulses, status bits 12:8 capture `arb_pos_i`. The field holds its value between such events.
- R8: The interrupt flags are, from bit 0 up: receive, transmit done, error warning, overrun, wakeup, error passive, arbitration lost and bus error, with `evt_i` using the same bit positions. An event sets its flag only if the enable bit at the same position was 1 before the edge.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. An event and a clear of the same flag in one cycle leave the flag set.
- R10: `irq_o` is 1 exactly when some flag bit and its enable bit are both 1. Clearing the enable bits drops `irq_o` without clearing the flags.
- R11: The error-count register holds the transmit count in bits 7:0 and the receive count in bits 23:16, also driven on `tec_o` and `rec_o`. `cnt_ld_i` loads both counts from `tec_i` and `rec_i`. A host write of 0 clears both counts and takes priority over a load in the same cycle. A nonzero write is ignored.
- R12: Reads return the addressed register in the same cycle at the offsets stated above. Reads return 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| evt_i | input | 8 | Engine event pulses, one per flag position |
| eng_stat_i | input | 8 | Engine status levels (bit 1 not used) |
| berr_type_i | input | 2 | Bus error type |
| berr_dir_i | input | 1 | Bus error direction, 1 receive |
| berr_seg_i | input | 5 | Frame segment code of the bus error |
| arb_pos_i | input | 5 | Bit position where arbitration was lost |
| cnt_ld_i | input | 1 | Load the error counts |
| tec_i | input | 8 | Transmit error count to load |
| rec_i | input | 8 | Receive error count to load |
| mode_o | output | 5 | Mode levels to the engine |
| cmd_o | output | 6 | Command pulses to the engine |
| tec_o | output | 8 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| irq_o | output | 1 | Level interrupt |

## Verification
Every stored result becomes visible one clock after the edge that samples its cause. This covers mode bits, command pulses, flags, the overrun latch, the captured fields, the mirrored status levels and the counts. `irq_o` and the read data follow those registers with no further delay. The bench therefore drives stimulus 1 ns after a rising edge and compares against its reference model at the falling edge of the same cycle, after the model has applied the stimulus of the previous edge. Directed reads sample 3 ns after the edge that follows a write or an event, where the new value is already registered. Command pulses are checked on the first cycle after the write and again one cycle later, when they must be gone.

// File: rtl/can_host_pkg.sv
package can_host_pkg;
    // register byte offsets
    localparam int OFS_MODE = 'h00;
    localparam int OFS_CMD  = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_IRQF = 'h0C;
    localparam int OFS_IRQE = 'h10;
    localparam int OFS_ERRC = 'h14;

    // mode bits
    localparam int MB_RESET  = 0;
    localparam int MB_LISTEN = 1;
    localparam int MB_LOOP   = 2;
    localparam int MB_FILT   = 3;
    localparam int MB_SLEEP  = 4;

    // command bits
    localparam int CB_XMIT    = 0;
    localparam int CB_ABORT   = 1;
    localparam int CB_RELEASE = 2;
    localparam int CB_CLROVR  = 3;
    localparam int CB_SELFRX  = 4;
    localparam int CB_BUSOFF  = 5;

    // event / flag bits
    localparam int EV_RX    = 0;
    localparam int EV_TXD   = 1;
    localparam int EV_EWARN = 2;
    localparam int EV_OVR   = 3;
    localparam int EV_WAKE  = 4;
    localparam int EV_EPASS = 5;
    localparam int EV_ARB   = 6;
    localparam int EV_BERR  = 7;

    // status bits and fields
    localparam int SB_RXRDY   = 0;
    localparam int SB_OVR     = 1;
    localparam int SF_ALC_LSB = 8;
    localparam int SF_SEG_LSB = 16;
    localparam int SF_DIR     = 21;
    localparam int SF_TYP_LSB = 22;
    localparam int EF_REC_LSB = 16;

    localparam logic [7:0] STAT_RESET = 8'h3C;
endpackage

// File: rtl/chr_mode_cmd.sv
module chr_mode_cmd
    import can_host_pkg::*;
#(
    parameter int MODE_W = 5,
    parameter int CMD_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr_i,
    input  logic [MODE_W-1:0] mode_wdata_i,
    input  logic              cmd_wr_i,
    input  logic [CMD_W-1:0]  cmd_wdata_i,
    input  logic              rx_ready_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [CMD_W-1:0]  cmd_o
);
    localparam logic [MODE_W-1:0] MODE_RST_VAL = MODE_W'(1 << MB_RESET);
    localparam logic [MODE_W-1:0] CFG_MASK =
        MODE_W'((1 << MB_FILT) | (1 << MB_SLEEP));

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CMD_W-1:0]  cmd;
    } mc_state_t;

    mc_state_t st_d, st_q;
    logic [MODE_W-1:0] wmask_d;

    always_comb begin
        st_d     = st_q;
        st_d.cmd = '0;
        wmask_d  = st_q.mode[MB_RESET] ? '1 : ~CFG_MASK;
        if (mode_wr_i)
            st_d.mode = (st_q.mode & ~wmask_d) | (mode_wdata_i & wmask_d);
        if (cmd_wr_i) begin
            st_d.cmd = cmd_wdata_i;
            if (!rx_ready_i)
                st_d.cmd[CB_RELEASE] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RST_VAL;
            st_q.cmd  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign cmd_o  = st_q.cmd;

    // R2: configuration bits frozen while out of reset mode
    p_cfg_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode[MB_RESET] |=> $stable(st_q.mode[MB_SLEEP:MB_FILT]))
        else $error("p_cfg_lock_r2");

    // R3: a command pulse only follows a command write
    p_cmd_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_o) |-> $past(cmd_wr_i))
        else $error("p_cmd_origin_r3");

    // R4: release only when a frame was pending
    p_release_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o[CB_RELEASE] |-> $past(rx_ready_i))
        else $error("p_release_gate_r4");
endmodule

// File: rtl/chr_irq.sv
module chr_irq #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] evt_i,
    input  logic               flag_wr_i,
    input  logic               en_wr_i,
    input  logic [NUM_IRQ-1:0] wdata_i,
    output logic [NUM_IRQ-1:0] flags_o,
    output logic [NUM_IRQ-1:0] en_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] flags;
        logic [NUM_IRQ-1:0] en;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [NUM_IRQ-1:0] clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = flag_wr_i ? wdata_i : '0;
        // set after clear: an event in the same cycle wins
        st_d.flags = (st_q.flags & ~clr_d) | (evt_i & st_q.en);
        if (en_wr_i)
            st_d.en = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign en_o    = st_q.en;
    assign irq_o   = |(st_q.flags & st_q.en);

    // R8: a newly set flag had its enable set before the edge
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flags & ~$past(st_q.flags) & ~$past(st_q.en)) == '0))
        else $error("p_gate_r8");

    // R9: written ones clear unless an event hit the same bit
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr_i |=> ((st_q.flags & $past(wdata_i) & ~$past(evt_i)) == '0))
        else $error("p_w1c_r9");

    // R10: the interrupt rises only from an enabled event or an enable write
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (($past(evt_i & st_q.en) != '0) || $past(en_wr_i)))
        else $error("p_irq_cause_r10");
endmodule

// File: rtl/chr_status.sv
module chr_status
    import can_host_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEG_W = 5,
    parameter int ALC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       eng_stat_i,
    input  logic             ovr_evt_i,
    input  logic             clr_ovr_i,
    input  logic             berr_evt_i,
    input  logic [1:0]       berr_type_i,
    input  logic             berr_dir_i,
    input  logic [SEG_W-1:0] berr_seg_i,
    input  logic             arb_evt_i,
    input  logic [ALC_W-1:0] arb_pos_i,
    input  logic             cnt_ld_i,
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    input  logic             cnt_clr_i,
    output logic [7:0]       stat_o,
    output logic [1:0]       etype_o,
    output logic             edir_o,
    output logic [SEG_W-1:0] eseg_o,
    output logic [ALC_W-1:0] alc_o,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o
);
    typedef struct packed {
        logic [7:0]       stat;
        logic [1:0]       etype;
        logic             edir;
        logic [SEG_W-1:0] eseg;
        logic [ALC_W-1:0] alc;
        logic [CNT_W-1:0] tec;
        logic [CNT_W-1:0] rec;
    } st_state_t;

    st_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = eng_stat_i;
        // overrun latch: clear first, then set so the event wins
        st_d.stat[SB_OVR] = st_q.stat[SB_OVR];
        if (clr_ovr_i) st_d.stat[SB_OVR] = 1'b0;
        if (ovr_evt_i) st_d.stat[SB_OVR] = 1'b1;
        if (berr_evt_i) begin
            st_d.etype = berr_type_i;
            st_d.edir  = berr_dir_i;
            st_d.eseg  = berr_seg_i;
        end
        if (arb_evt_i)
            st_d.alc = arb_pos_i;
        if (cnt_clr_i) begin
            st_d.tec = '0;
            st_d.rec = '0;
        end else if (cnt_ld_i) begin
            st_d.tec = tec_i;
            st_d.rec = rec_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stat <= STAT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o  = st_q.stat;
    assign etype_o = st_q.etype;
    assign edir_o  = st_q.edir;
    assign eseg_o  = st_q.eseg;
    assign alc_o   = st_q.alc;
    assign tec_o   = st_q.tec;
    assign rec_o   = st_q.rec;

    // R5: overrun latch set and clear behaviour
    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt_i |=> stat_o[SB_OVR])
        else $error("p_ovr_set_r5");
    p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovr_i && !ovr_evt_i) |=> !stat_o[SB_OVR])
        else $error("p_ovr_clear_r5");

    // R6: bus error capture and hold
    p_berr_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        berr_evt_i |=> (etype_o == $past(berr_type_i)) && (edir_o == $past(berr_dir_i))
                       && (eseg_o == $past(berr_seg_i)))
        else $error("p_berr_cap_r6");
    p_berr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_evt_i |=> $stable(eseg_o) && $stable(etype_o) && $stable(edir_o))
        else $error("p_berr_hold_r6");

    // R7: arbitration position holds between events
    p_arb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_evt_i |=> $stable(alc_o))
        else $error("p_arb_hold_r7");

    // R11: host clear beats a load
    p_cnt_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_i |=> (tec_o == '0) && (rec_o == '0))
        else $error("p_cnt_clear_r11");
endmodule

// File: rtl/can_host_regs.sv
module can_host_regs
    import can_host_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int NUM_IRQ = 8,
    parameter int MODE_W  = 5,
    parameter int CMD_W   = 6,
    parameter int CNT_W   = 8,
    parameter int SEG_W   = 5,
    parameter int ALC_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NUM_IRQ-1:0] evt_i,
    input  logic [7:0]        eng_stat_i,
    input  logic [1:0]        berr_type_i,
    input  logic              berr_dir_i,
    input  logic [SEG_W-1:0]  berr_seg_i,
    input  logic [ALC_W-1:0]  arb_pos_i,
    input  logic              cnt_ld_i,
    input  logic [CNT_W-1:0]  tec_i,
    input  logic [CNT_W-1:0]  rec_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [CNT_W-1:0]  tec_o,
    output logic [CNT_W-1:0]  rec_o,
    output logic              irq_o
);
    logic wr_q_unused;
    logic acc_wr, acc_rd;
    logic hit_mode, hit_cmd, hit_stat, hit_irqf, hit_irqe, hit_errc;

    logic [NUM_IRQ-1:0] flags, en;
    logic [7:0]         stat;
    logic [1:0]         etype;
    logic               edir;
    logic [SEG_W-1:0]   eseg;
    logic [ALC_W-1:0]   alc;

    assign wr_q_unused = 1'b0;
    assign acc_wr   = bus_sel_i & bus_we_i;
    assign acc_rd   = bus_sel_i & ~bus_we_i;
    assign hit_mode = (bus_addr_i == ADDR_W'(OFS_MODE));
    assign hit_cmd  = (bus_addr_i == ADDR_W'(OFS_CMD));
    assign hit_stat = (bus_addr_i == ADDR_W'(OFS_STAT));
    assign hit_irqf = (bus_addr_i == ADDR_W'(OFS_IRQF));
    assign hit_irqe = (bus_addr_i == ADDR_W'(OFS_IRQE));
    assign hit_errc = (bus_addr_i == ADDR_W'(OFS_ERRC));

    chr_mode_cmd #(.MODE_W(MODE_W), .CMD_W(CMD_W)) u_mode_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr_i    (acc_wr & hit_mode),
        .mode_wdata_i (bus_wdata_i[MODE_W-1:0]),
        .cmd_wr_i     (acc_wr & hit_cmd),
        .cmd_wdata_i  (bus_wdata_i[CMD_W-1:0]),
        .rx_ready_i   (stat[SB_RXRDY]),
        .mode_o       (mode_o),
        .cmd_o        (cmd_o)
    );

    chr_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .flag_wr_i (acc_wr & hit_irqf),
        .en_wr_i   (acc_wr & hit_irqe),
        .wdata_i   (bus_wdata_i[NUM_IRQ-1:0]),
        .flags_o   (flags),
        .en_o      (en),
        .irq_o     (irq_o)
    );

    chr_status #(.CNT_W(CNT_W), .SEG_W(SEG_W), .ALC_W(ALC_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .eng_stat_i  (eng_stat_i),
        .ovr_evt_i   (evt_i[EV_OVR]),
        .clr_ovr_i   (acc_wr & hit_cmd & bus_wdata_i[CB_CLROVR]),
        .berr_evt_i  (evt_i[EV_BERR]),
        .berr_type_i (berr_type_i),
        .berr_dir_i  (berr_dir_i),
        .berr_seg_i  (berr_seg_i),
        .arb_evt_i   (evt_i[EV_ARB]),
        .arb_pos_i   (arb_pos_i),
        .cnt_ld_i    (cnt_ld_i),
        .tec_i       (tec_i),
        .rec_i       (rec_i),
        .cnt_clr_i   (acc_wr & hit_errc & (bus_wdata_i == '0)),
        .stat_o      (stat),
        .etype_o     (etype),
        .edir_o      (edir),
        .eseg_o      (eseg),
        .alc_o       (alc),
        .tec_o       (tec_o),
        .rec_o       (rec_o)
    );

    // same-cycle read mux; the command offset always reads zero
    always_comb begin
        bus_rdata_o = '0;
        if (acc_rd) begin
            if (hit_mode) begin
                bus_rdata_o[MODE_W-1:0] = mode_o;
            end else if (hit_stat) begin
                bus_rdata_o[7:0]                  = stat;
                bus_rdata_o[SF_ALC_LSB +: ALC_W]  = alc;
                bus_rdata_o[SF_SEG_LSB +: SEG_W]  = eseg;
                bus_rdata_o[SF_DIR]               = edir;
                bus_rdata_o[SF_TYP_LSB +: 2]      = etype;
            end else if (hit_irqf) begin
                bus_rdata_o[NUM_IRQ-1:0] = flags;
            end else if (hit_irqe) begin
                bus_rdata_o[NUM_IRQ-1:0] = en;
            end else if (hit_errc) begin
                bus_rdata_o[CNT_W-1:0]          = tec_o;
                bus_rdata_o[EF_REC_LSB +: CNT_W] = rec_o;
            end else begin
                bus_rdata_o[0] = wr_q_unused;
            end
        end
    end

    // R12: nothing is driven on the read bus without a selected read
    p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |-> (bus_rdata_o == '0))
        else $error("p_rd_idle_r12");
endmodule

// File: tb/can_host_regs_tb_top.sv
`timescale 1ns/1ps
module can_host_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt = '0;
    logic [7:0]  eng_stat = 8'h3C;
    logic [1:0]  berr_type = '0;
    logic        berr_dir = 1'b0;
    logic [4:0]  berr_seg = '0;
    logic [4:0]  arb_pos = '0;
    logic        cnt_ld = 1'b0;
    logic [7:0]  tec_in = '0, rec_in = '0;
    logic [4:0]  mode_o;
    logic [5:0]  cmd_o;
    logic [7:0]  tec_o, rec_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    can_host_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .evt_i(evt), .eng_stat_i(eng_stat),
        .berr_type_i(berr_type), .berr_dir_i(berr_dir), .berr_seg_i(berr_seg),
        .arb_pos_i(arb_pos), .cnt_ld_i(cnt_ld), .tec_i(tec_in), .rec_i(rec_in),
        .mode_o(mode_o), .cmd_o(cmd_o), .tec_o(tec_o), .rec_o(rec_o), .irq_o(irq_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [4:0] m_mode;
    logic [5:0] m_cmd;
    logic [7:0] m_flags, m_en, m_stat, m_tec, m_rec;
    logic [1:0] m_etype;
    logic       m_edir;
    logic [4:0] m_eseg, m_alc;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 5'h01; m_cmd = 0; m_flags = 0; m_en = 0; m_stat = 8'h3C;
            m_tec = 0; m_rec = 0; m_etype = 0; m_edir = 0; m_eseg = 0; m_alc = 0;
        end else begin
            logic wr;
            logic ovr;
            logic [7:0] old_en;
            wr = bus_sel && bus_we;
            old_en = m_en;
            m_cmd = 0;
            ovr = m_stat[1];
            if (wr && bus_addr == 8'h04) begin
                m_cmd = bus_wdata[5:0];
                if (!m_stat[0]) m_cmd[2] = 1'b0;
                if (bus_wdata[3]) ovr = 1'b0;
            end
            if (wr && bus_addr == 8'h00) begin
                if (m_mode[0]) m_mode = bus_wdata[4:0];
                else           m_mode = {m_mode[4:3], bus_wdata[2:0]};
            end
            if (wr && bus_addr == 8'h0C) m_flags = m_flags & ~bus_wdata[7:0];
            m_flags = m_flags | (evt & old_en);
            if (wr && bus_addr == 8'h10) m_en = bus_wdata[7:0];
            if (evt[3]) ovr = 1'b1;
            m_stat = eng_stat;
            m_stat[1] = ovr;
            if (evt[7]) begin m_etype = berr_type; m_edir = berr_dir; m_eseg = berr_seg; end
            if (evt[6]) m_alc = arb_pos;
            if (wr && bus_addr == 8'h14 && bus_wdata == 0) begin m_tec = 0; m_rec = 0; end
            else if (cnt_ld) begin m_tec = tec_in; m_rec = rec_in; end
        end
    end

    function automatic logic [31:0] m_rdata();
        logic [31:0] r;
        r = 0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                8'h00: r[4:0] = m_mode;
                8'h08: r = {8'h00, m_etype, m_edir, m_eseg, 3'b000, m_alc, m_stat};
                8'h0C: r[7:0] = m_flags;
                8'h10: r[7:0] = m_en;
                8'h14: r = {8'h00, m_rec, 8'h00, m_tec};
                default: r = 0;
            endcase
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock, mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 mode_o vs model", 32'(mode_o), 32'(m_mode));
            chk("R3 cmd_o vs model", 32'(cmd_o), 32'(m_cmd));
            chk("R10 irq_o vs model", 32'(irq_o), 32'(|(m_flags & m_en)));
            chk("R11 counts vs model", {16'h0, rec_o, tec_o}, {16'h0, m_rec, m_tec});
            chk("R12 rdata vs model", bus_rdata, m_rdata());
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [7:0] e = 0);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; evt = e;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0; evt = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #2;
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic pulse(input logic [7:0] e);
        @(posedge clk); #1;
        evt = e;
        @(posedge clk); #1;
        evt = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired act=hung exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        rd(8'h00, r); chk("R1 mode reset", r, 32'h01);
        rd(8'h08, r); chk("R1 status reset", r, 32'h3C);
        rd(8'h0C, r); chk("R1 flags reset", r, 0);
        rd(8'h10, r); chk("R1 enables reset", r, 0);
        rd(8'h14, r); chk("R1 counts reset", r, 0);
        chk("R1 cmd_o reset", 32'(cmd_o), 0);

        // R2: configuration lock
        wr(8'h00, 32'h1F); rd(8'h00, r); chk("R2 all bits in reset mode", r, 32'h1F);
        wr(8'h00, 32'h18); rd(8'h00, r); chk("R2 leave reset mode", r, 32'h18);
        wr(8'h00, 32'h00); rd(8'h00, r); chk("R2 cfg locked", r, 32'h18);
        wr(8'h00, 32'h06); rd(8'h00, r); chk("R2 low bits writable", r, 32'h1E);
        wr(8'h00, 32'h01); rd(8'h00, r); chk("R2 lock judged before write", r, 32'h19);
        wr(8'h00, 32'h00); chk("R2 cfg change in reset mode", 32'(mode_o), 0);
        wr(8'h00, 32'h01);

        // R3: command pulses
        wr(8'h04, 32'h3B); chk("R3 pulse cycle", 32'(cmd_o), 32'h3B);
        @(posedge clk); #1; chk("R3 pulse gone", 32'(cmd_o), 0);
        rd(8'h04, r); chk("R3 cmd reads zero", r, 0);

        // R4: release gated by receive-ready
        wr(8'h04, 32'h04); chk("R4 release without frame", 32'(cmd_o), 0);
        eng_stat = 8'h3D;
        wr(8'h04, 32'h04); chk("R4 release with frame", 32'(cmd_o), 32'h04);

        // R8: enable gating
        pulse(8'hFF); rd(8'h0C, r); chk("R8 disabled events", r, 0);
        chk("R10 no irq when disabled", 32'(irq_o), 0);
        wr(8'h10, 32'h05);
        pulse(8'hFF); rd(8'h0C, r); chk("R8 enabled flags only", r, 32'h05);
        chk("R10 irq asserted", 32'(irq_o), 1);

        // R9: write-one-to-clear, event wins
        wr(8'h0C, 32'h01); rd(8'h0C, r); chk("R9 w1c", r, 32'h04);
        wr(8'h0C, 32'h00); rd(8'h0C, r); chk("R9 zero write", r, 32'h04);
        wr(8'h0C, 32'h04, 8'h04); rd(8'h0C, r); chk("R9 event beats clear", r, 32'h04);
        wr(8'h0C, 32'h04); rd(8'h0C, r); chk("R9 cleared", r, 0);
        chk("R10 irq drops", 32'(irq_o), 0);

        // R10: masking hides pending flags
        wr(8'h10, 32'hFF); pulse(8'h02); chk("R10 tx done irq", 32'(irq_o), 1);
        wr(8'h10, 32'h00); chk("R10 masked", 32'(irq_o), 0);
        rd(8'h0C, r); chk("R10 flag kept", r, 32'h02);
        wr(8'h0C, 32'hFF);

        // R5: overrun latch and status mirroring
        rd(8'h08, r); chk("R5 overrun set", r[7:0], 32'h3F);
        wr(8'h04, 32'h08); rd(8'h08, r); chk("R5 overrun cleared", r[7:0], 32'h3D);
        wr(8'h04, 32'h08, 8'h08); rd(8'h08, r); chk("R5 set beats clear", r[7:0], 32'h3F);
        wr(8'h04, 32'h08);
        eng_stat = 8'hF3;
        rd(8'h08, r); chk("R5 mirror ignores bit1", r[7:0], 32'hF1);

        // R6: bus error capture
        berr_type = 2'd2; berr_dir = 1'b1; berr_seg = 5'h0A;
        pulse(8'h80); rd(8'h08, r); chk("R6 capture", r, 32'h00AA00F1);
        berr_type = 2'd1; berr_dir = 1'b0; berr_seg = 5'h11;
        repeat (2) @(posedge clk);
        rd(8'h08, r); chk("R6 hold", r, 32'h00AA00F1);
        berr_type = 2'd0; berr_seg = 5'h1C;
        pulse(8'h80); rd(8'h08, r); chk("R6 second capture", r, 32'h001C00F1);

        // R7: arbitration position
        arb_pos = 5'h13;
        pulse(8'h40); rd(8'h08, r); chk("R7 capture", r, 32'h001C13F1);
        arb_pos = 5'h02;
        repeat (2) @(posedge clk);
        rd(8'h08, r); chk("R7 hold", r[12:8], 32'h13);

        // R11: error counts
        @(posedge clk); #1; tec_in = 8'h60; rec_in = 8'h81; cnt_ld = 1;
        @(posedge clk); #1; cnt_ld = 0;
        rd(8'h14, r); chk("R11 load", r, 32'h00810060);
        chk("R11 ports", {16'h0, rec_o, tec_o}, 32'h00008160);
        wr(8'h14, 32'h5); rd(8'h14, r); chk("R11 nonzero ignored", r, 32'h00810060);
        wr(8'h14, 32'h0); rd(8'h14, r); chk("R11 clear", r, 0);
        @(posedge clk); #1; cnt_ld = 1; tec_in = 8'h22; rec_in = 8'h33;
        bus_sel = 1; bus_we = 1; bus_addr = 8'h14; bus_wdata = 0;
        @(posedge clk); #1; cnt_ld = 0; bus_sel = 0; bus_we = 0;
        rd(8'h14, r); chk("R11 clear beats load", r, 0);

        // R12: idle read bus and unmapped offset
        @(posedge clk); #1; chk("R12 idle rdata", bus_rdata, 0);
        rd(8'h3C, r); chk("R12 unmapped", r, 0);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule